// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the line and frame timing for a raster panel or CRT monitor. A pixel counter and a line counter step forward on each cycle in which the pixel-clock enable is high. From their values the block derives four things: a horizontal sync pulse, a vertical sync pulse, a display-enable flag and the current pixel and line positions.

All horizontal quantities are programmed in units of eight pixels. The horizontal sync start has a fixed two-pixel early offset. All vertical quantities are programmed in single lines. Each of the two syncs has its own polarity bit.

The timing fields are written through a small address/data write port into working registers. Those values are copied into the shadow set that drives the counters only when the raster wraps to its origin, so a frame in progress always runs on one consistent set of values. A host writes the fields at any time and the new timing starts with the next frame.

Top module: `raster_timing_gen`

## Requirements
- R1: On synchronous reset both counters read 0 and both syncs sit at their inactive level. The reset settings have both polarities active-high, so both sync outputs read 0. Display-enable reads 1, because the origin lies inside the active area.
- R2: The pixel counter advances by one only in cycles where `pix_en` is high and holds otherwise. It returns to 0 after the last pixel of a line, whose length is 8·(A+1) + 8·(B+1) with A the active-width field and B the horizontal-blank field. `line_y` advances by one at that wrap.
- R3: A frame lasts (V+1) + (W+1) lines, with V the active-height field and W the vertical-blank field. After its last pixel both counters return to 0.
- R4: `de` is 1 exactly when `pix_x` < 8·(A+1) and `line_y` < V+1.
- R5: The horizontal sync is active for `pix_x` in [8·(A+1) + 8·(S+1) − 2, that value + 8·(P+1)). S is the sync-start field and P the sync-width field. The pulse is cut short at the end of the line.
- R6: The vertical sync is active for `line_y` in [(V+1) + (T+1), that value + (Q+1)). T is the vertical sync-start field and Q the vertical sync-width field.
- R7: A polarity bit of 1 makes its sync active-high and 0 makes it active-low. The horizontal polarity is `wr_data[4]` at address 3 and the vertical polarity is `wr_data[3]` at address 7.
- R8: A write that lands during a frame does not change that frame's timing. The new value governs from the next frame origin on.
- R9: Field map, by `wr_addr`, with each field in the low bits of `wr_data`:
  - 0: A (7 bits)
  - 1: B (5 bits)
  - 2: S (5 bits)
  - 3: P (4 bits)
  - 4: V (10 bits)
  - 5: W (6 bits)
  - 6: T (6 bits)
  - 7: Q (3 bits)

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel-clock enable; advances the counters |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Field select |
| wr_data | input | 10 | Field value (low bits) plus polarity bit |
| hsync | output | 1 | Horizontal sync / line pulse |
| vsync | output | 1 | Vertical sync / frame pulse |
| de | output | 1 | Display-enable |
| pix_x | output | 11 | Current pixel position in the line |
| line_y | output | 11 | Current line position in the frame |

## Verification
A wrong counter limit shows up on the position outputs as soon as the first line or frame would wrap. The line or frame comes out the wrong length, and every sync and enable edge after it is displaced. A shadow register that takes its value at the wrong time gives a frame whose line length changes partway through, which is visible within one line of the write. A bad polarity or window bound shows on the sync pin in the first blanking interval after the settings take effect.

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int HA_W = 7,
  parameter int HB_W = 5,
  parameter int HS_W = 5,
  parameter int HW_W = 4,
  parameter int VA_W = 10,
  parameter int VB_W = 6,
  parameter int VS_W = 6,
  parameter int VW_W = 3,
  localparam int XW = $clog2(((2**HA_W) + (2**HB_W)) * 8 + 2**HW_W * 8 + 1),
  localparam int YW = $clog2((2**VA_W) + (2**VB_W) + (2**VS_W) + 1),
  localparam int DW = VA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [XW-1:0] pix_x,
  output logic [YW-1:0] line_y
);

  localparam logic [HA_W-1:0] D_HA = HA_W'(1);
  localparam logic [HB_W-1:0] D_HB = HB_W'(2);
  localparam logic [HS_W-1:0] D_HS = HS_W'(1);
  localparam logic [HW_W-1:0] D_HW = HW_W'(0);
  localparam logic [VA_W-1:0] D_VA = VA_W'(3);
  localparam logic [VB_W-1:0] D_VB = VB_W'(3);
  localparam logic [VS_W-1:0] D_VS = VS_W'(0);
  localparam logic [VW_W-1:0] D_VW = VW_W'(0);

  logic [HA_W-1:0] r_ha, s_ha;
  logic [HB_W-1:0] r_hb, s_hb;
  logic [HS_W-1:0] r_hs, s_hs;
  logic [HW_W-1:0] r_hw, s_hw;
  logic [VA_W-1:0] r_va, s_va;
  logic [VB_W-1:0] r_vb, s_vb;
  logic [VS_W-1:0] r_vs, s_vs;
  logic [VW_W-1:0] r_vw, s_vw;
  logic            r_hpol, s_hpol, r_vpol, s_vpol;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_ha <= D_HA; r_hb <= D_HB; r_hs <= D_HS; r_hw <= D_HW; r_hpol <= 1'b1;
      r_va <= D_VA; r_vb <= D_VB; r_vs <= D_VS; r_vw <= D_VW; r_vpol <= 1'b1;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: r_ha <= wr_data[HA_W-1:0];
        3'd1: r_hb <= wr_data[HB_W-1:0];
        3'd2: r_hs <= wr_data[HS_W-1:0];
        3'd3: begin r_hw <= wr_data[HW_W-1:0]; r_hpol <= wr_data[HW_W]; end
        3'd4: r_va <= wr_data[VA_W-1:0];
        3'd5: r_vb <= wr_data[VB_W-1:0];
        3'd6: r_vs <= wr_data[VS_W-1:0];
        default: begin r_vw <= wr_data[VW_W-1:0]; r_vpol <= wr_data[VW_W]; end
      endcase
    end
  end

  logic [XW-1:0] h_act, h_tot, hs_beg, hs_end;
  logic [YW-1:0] v_act, v_tot, vs_beg, vs_end;

  assign h_act  = XW'({s_ha, 3'b000}) + XW'(8);
  assign h_tot  = h_act  + XW'({s_hb, 3'b000}) + XW'(8);
  assign hs_beg = h_act  + XW'({s_hs, 3'b000}) + XW'(6);
  assign hs_end = hs_beg + XW'({s_hw, 3'b000}) + XW'(8);
  assign v_act  = YW'(s_va) + YW'(1);
  assign v_tot  = v_act  + YW'(s_vb) + YW'(1);
  assign vs_beg = v_act  + YW'(s_vs) + YW'(1);
  assign vs_end = vs_beg + YW'(s_vw) + YW'(1);

  logic x_last, y_last, frame_end;
  assign x_last    = (pix_x == h_tot - XW'(1));
  assign y_last    = (line_y == v_tot - YW'(1));
  assign frame_end = pix_en && x_last && y_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_ha <= D_HA; s_hb <= D_HB; s_hs <= D_HS; s_hw <= D_HW; s_hpol <= 1'b1;
      s_va <= D_VA; s_vb <= D_VB; s_vs <= D_VS; s_vw <= D_VW; s_vpol <= 1'b1;
    end else if (frame_end) begin
      s_ha <= r_ha; s_hb <= r_hb; s_hs <= r_hs; s_hw <= r_hw; s_hpol <= r_hpol;
      s_va <= r_va; s_vb <= r_vb; s_vs <= r_vs; s_vw <= r_vw; s_vpol <= r_vpol;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_x  <= '0;
      line_y <= '0;
    end else if (pix_en) begin
      if (x_last) begin
        pix_x  <= '0;
        line_y <= y_last ? '0 : line_y + YW'(1);
      end else begin
        pix_x <= pix_x + XW'(1);
      end
    end
  end

  logic hs_on, vs_on;
  assign hs_on = (pix_x >= hs_beg) && (pix_x < hs_end);
  assign vs_on = (line_y >= vs_beg) && (line_y < vs_end);
  assign hsync = hs_on ~^ s_hpol;
  assign vsync = vs_on ~^ s_vpol;
  assign de    = (pix_x < h_act) && (line_y < v_act);

endmodule

module raster_timing_gen_chk #(
  parameter int XW = 11,
  parameter int YW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_en,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic [XW-1:0] pix_x,
  input logic [YW-1:0] line_y,
  input logic          hpol,
  input logic          vpol
);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> ($stable(pix_x) && $stable(line_y)));

  // R2
  pixel_step_chk: assert property (@(posedge clk) disable iff (rst)
    pix_en |=> ((pix_x == $past(pix_x) + XW'(1)) || (pix_x == '0)));

  // R3
  line_moves_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(line_y) |-> (pix_x == '0));

  // R6
  vsync_at_line_start_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(vsync) |-> (pix_x == '0));

  // R5
  no_hsync_in_active_chk: assert property (@(posedge clk) disable iff (rst)
    de |-> (hsync != hpol));

  // R6
  no_vsync_in_active_chk: assert property (@(posedge clk) disable iff (rst)
    de |-> (vsync != vpol));

endmodule

bind raster_timing_gen raster_timing_gen_chk #(.XW(XW), .YW(YW)) chk (
  .clk(clk), .rst(rst), .pix_en(pix_en), .hsync(hsync), .vsync(vsync),
  .de(de), .pix_x(pix_x), .line_y(line_y), .hpol(s_hpol), .vpol(s_vpol)
);

// File: tb/raster_timing_gen_test.sv
module raster_timing_gen_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_en = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [9:0] wr_data = '0;
  logic hsync, vsync, de;
  logic [10:0] pix_x, line_y;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  int ha = 1, hb = 2, hs = 1, hw = 0, hp = 1;
  int va = 3, vb = 3, vs = 0, vw = 0, vp = 1;

  always #2 clk = ~clk;

  raster_timing_gen uut (
    .clk(clk), .rst(rst), .pix_en(pix_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .de(de),
    .pix_x(pix_x), .line_y(line_y)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 10'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic program_all(input int a, b, s, w, p, v, vbl, t, q, vpl);
    write_reg(0, a); write_reg(1, b); write_reg(2, s); write_reg(3, (p << 4) | w);
    write_reg(4, v); write_reg(5, vbl); write_reg(6, t); write_reg(7, (vpl << 3) | q);
    ha = a; hb = b; hs = s; hw = w; hp = p; va = v; vb = vbl; vs = t; vw = q; vp = vpl;
  endtask

  task automatic wait_origin();
    while (pix_x == 0 && line_y == 0) @(negedge clk);
    while (!(pix_x == 0 && line_y == 0)) @(negedge clk);
  endtask

  task automatic scan_frame(input string tag);
    int hact, ht, hsb, hse, vact, vt, vsb, vse;
    int e_pos, e_de, e_hs, e_vs;
    int a_pos, x_pos, a_hs, x_hs, a_vs, x_vs;
    hact = 8 * (ha + 1); ht = hact + 8 * (hb + 1);
    hsb = hact + 8 * (hs + 1) - 2; hse = hsb + 8 * (hw + 1);
    vact = va + 1; vt = vact + vb + 1;
    vsb = vact + vs + 1; vse = vsb + vw + 1;
    e_pos = 0; e_de = 0; e_hs = 0; e_vs = 0;
    a_pos = 0; x_pos = 0; a_hs = 0; x_hs = 0; a_vs = 0; x_vs = 0;
    wait_origin();
    for (int y = 0; y < vt; y++) begin
      for (int x = 0; x < ht; x++) begin
        bit hon, von, ede;
        hon = (x >= hsb) && (x < hse);
        von = (y >= vsb) && (y < vse);
        ede = (x < hact) && (y < vact);
        if (pix_x != 11'(x) || line_y != 11'(y)) begin
          if (e_pos == 0) begin a_pos = pix_x * 4096 + line_y; x_pos = x * 4096 + y; end
          e_pos++;
        end
        if (de != ede) e_de++;
        if (hsync != (hp ? hon : !hon)) begin
          if (e_hs == 0) begin a_hs = hsync; x_hs = hp ? hon : !hon; end
          e_hs++;
        end
        if (vsync != (vp ? von : !von)) begin
          if (e_vs == 0) begin a_vs = vsync; x_vs = vp ? von : !von; end
          e_vs++;
        end
        @(negedge clk);
      end
    end
    check(e_pos == 0, {tag, " R2 position (x*4096+y)"}, a_pos, x_pos);
    check(pix_x == 0 && line_y == 0, {tag, " R3 frame wrap line"}, line_y, 0);
    check(e_de == 0, {tag, " R4 de mismatches"}, e_de, 0);
    check(e_hs == 0, {tag, " R5/R7 hsync level"}, a_hs, x_hs);
    check(e_vs == 0, {tag, " R6/R7 vsync level"}, a_vs, x_vs);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(pix_x == 0, "R1 pix_x after reset", pix_x, 0);
    check(line_y == 0, "R1 line_y after reset", line_y, 0);
    check(hsync == 0, "R1 hsync inactive", hsync, 0);
    check(vsync == 0, "R1 vsync inactive", vsync, 0);
    check(de == 1, "R1 de at origin", de, 1);
  endtask

  task automatic test_hold();
    logic [10:0] hx, hy;
    @(negedge clk);
    pix_en = 1'b0;
    hx = pix_x; hy = line_y;
    repeat (6) @(negedge clk);
    check(pix_x == hx, "R2 pix_x held while pix_en low", pix_x, hx);
    check(line_y == hy, "R2 line_y held while pix_en low", line_y, hy);
    pix_en = 1'b1;
    @(negedge clk);
    check(pix_x == hx + 1 || pix_x == 0, "R2 step after enable", pix_x, hx + 1);
  endtask

  task automatic test_no_tear();
    int n;
    wait_origin();
    while (line_y != 1) @(negedge clk);
    write_reg(0, 3);
    while (pix_x != 0) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (pix_x != 0);
    check(n == 8 * (ha + 1) + 8 * (hb + 1), "R8 line length unchanged mid-frame", n,
          8 * (ha + 1) + 8 * (hb + 1));
    ha = 3;
    scan_frame("R8 next frame");
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    pix_en = 1'b1;
    scan_frame("defaults");
    test_hold();
    program_all(2, 3, 0, 1, 0, 2, 4, 1, 2, 0);
    scan_frame("R9 low polarity");
    program_all(0, 3, 2, 3, 1, 1, 5, 2, 1, 1);
    scan_frame("R5 truncated hsync");
    test_no_tear();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule